// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block gathers interrupt request pulses from fourteen peripheral sources and turns them into a single request toward a CPU core. The request carries a vector number and a 3-bit level. Each source has a sticky pending flag, an enable bit and a programmable level. Level 0 disables a source. A higher level wins. Among sources at the same level, the lower vector number wins.

Sources that lose arbitration stay pending. Each time the core acknowledges the vector it was given, the block presents the next source in priority order. If a stronger source arrives while a request is waiting for the core, the outgoing vector and level switch to the stronger source. The displaced source stays pending.

Software reaches the block through a simple synchronous register bus:
- Address 0 holds the enable bits, one bit per source index.
- Address 1 shows the pending flags and takes write-one-to-clear.
- Addresses 2 to 8 each hold two level fields.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all enables, pending flags and level fields are 0, and `cpu_req` is low.
- R2: Level register at address 2+k holds the level of source 2k in bits [2:0] and the level of source 2k+1 in bits [10:8]. All other bits read as 0. Any address above 8 reads 0 and ignores writes.
- R3: A high `src_req[i]` sets pending bit i. Pending bit i is read at address 1 bit i. Writing a 1 to a pending bit clears only that bit. Writing 0 leaves it unchanged.
- R4: One clock after the pending, enable and level state changes, `cpu_req` is high exactly when some source is pending, enabled (address 0 bit i) and has a nonzero level. A level-0 or disabled source is never presented.
- R5: When several eligible sources are pending, `cpu_lvl` and `cpu_vec` show the one with the highest level.
- R6: Among eligible sources with equal level, the one with the lowest vector number is presented.
- R7: `cpu_ack` with `cpu_ack_vec` clears only the pending flag of the source owning that vector. An acknowledge of an unowned vector changes nothing. The next source in priority order is then presented.
- R8: If a higher-priority source becomes pending before the current request is acknowledged, the outputs switch to it and the displaced source stays pending.
- R9: Source indices 0..4 map to vectors 4..8 and indices 5..13 map to vectors 11..19. Vectors 9 and 10 are never output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 14 | Per-source request pulses |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational on address) |
| cpu_req | output | 1 | Request to the core |
| cpu_vec | output | 5 | Vector number of the presented source |
| cpu_lvl | output | 3 | Level of the presented source |
| cpu_ack | input | 1 | Core acceptance strobe |
| cpu_ack_vec | input | 5 | Vector being accepted |

## Verification
The hardest case to reach is retargeting: a stronger source must arrive while a weaker request is still waiting. The displaced source must then come back after the stronger one is acknowledged. The bench keeps `cpu_ack` low after presenting a weak source and pulses a higher-level source. It checks the switched outputs, reads the pending register to confirm that the weak source's flag survived, and then acknowledges in turn. Tie-breaking is set up by giving two sources the same level and a third a higher level in a single pulse. Draining that set one acknowledge at a time exposes the full ordering.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_SRC   = 14,
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 5,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int FIRST_VEC = 4,
  parameter int GAP_POS   = 5,
  parameter int GAP_LEN   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [13:0]        src_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               cpu_req,
  output logic [VEC_W-1:0]   cpu_vec,
  output logic [LVL_W-1:0]   cpu_lvl,
  input  logic               cpu_ack,
  input  logic [VEC_W-1:0]   cpu_ack_vec
);
  localparam int NUM_LREG  = (NUM_SRC + 1) / 2;
  localparam int A_EN      = 0;
  localparam int A_PEND    = 1;
  localparam int LREG_BASE = 2;
  localparam int HI_LSB    = 8;

  function automatic logic [VEC_W-1:0] vec_of(input int i);
    int v;
    v = (i < GAP_POS) ? FIRST_VEC + i : FIRST_VEC + GAP_LEN + i;
    return VEC_W'(v);
  endfunction

  logic [NUM_SRC-1:0] en_q, pend_q, elig;
  logic [LVL_W-1:0]   lvl_q [NUM_SRC];
  logic               win_ok;
  logic [VEC_W-1:0]   win_vec;
  logic [LVL_W-1:0]   win_lvl;

  wire wr_en   = bus_we && (bus_addr == ADDR_W'(A_EN));
  wire wr_pend = bus_we && (bus_addr == ADDR_W'(A_PEND));

  always_comb
    for (int i = 0; i < NUM_SRC; i++)
      elig[i] = pend_q[i] && en_q[i] && (lvl_q[i] != '0);

  always_comb begin
    win_ok  = 1'b0;
    win_vec = '0;
    win_lvl = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (elig[i] && lvl_q[i] >= win_lvl) begin
        win_ok  = 1'b1;
        win_vec = vec_of(i);
        win_lvl = lvl_q[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_req <= 1'b0;
      cpu_vec <= '0;
      cpu_lvl <= '0;
    end else begin
      cpu_req <= win_ok;
      cpu_vec <= win_vec;
      cpu_lvl <= win_lvl;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else if (wr_en) en_q <= bus_wdata[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cpu_ack && cpu_ack_vec == vec_of(i)) pend_q[i] <= 1'b0;
        if (wr_pend && bus_wdata[i])             pend_q[i] <= 1'b0;
        if (src_req[i])                          pend_q[i] <= 1'b1;
      end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
    end else if (bus_we) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (bus_addr == ADDR_W'(LREG_BASE + i / 2))
          lvl_q[i] <= (i % 2 == 1) ? bus_wdata[HI_LSB +: LVL_W] : bus_wdata[LVL_W-1:0];
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_EN))   bus_rdata[NUM_SRC-1:0] = en_q;
    if (bus_addr == ADDR_W'(A_PEND)) bus_rdata[NUM_SRC-1:0] = pend_q;
    for (int i = 0; i < NUM_SRC; i++)
      if (bus_addr == ADDR_W'(LREG_BASE + i / 2))
        bus_rdata[(i % 2) * HI_LSB +: LVL_W] = lvl_q[i];
  end

  AST_REQ_NONZERO_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> cpu_lvl != '0); // R4

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(|elig) |=> !cpu_req); // R4

  AST_VEC_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_vec >= vec_of(0) && cpu_vec <= vec_of(NUM_SRC-1) &&
                 !(cpu_vec > vec_of(GAP_POS-1) && cpu_vec < vec_of(GAP_POS)))); // R9

  AST_LVL_NOT_BEATEN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && $stable(elig) && $stable(en_q) |-> cpu_lvl >= win_lvl); // R5

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      src_req[g] |=> pend_q[g]); // R3
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[g] && !(cpu_ack && cpu_ack_vec == vec_of(g)) && !(wr_pend && bus_wdata[g])
      |=> pend_q[g]); // R3
  end
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [13:0] src_req = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cpu_req;
  logic [4:0]  cpu_vec;
  logic [2:0]  cpu_lvl;
  logic        cpu_ack = 0;
  logic [4:0]  cpu_ack_vec = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 4'(a); bus_we = 1; bus_wdata = 16'(d);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 4'(a);
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int m);
    @(negedge clk); src_req = 14'(m);
    @(negedge clk); src_req = '0;
    @(negedge clk);
  endtask

  task automatic ack(input int v);
    @(negedge clk); cpu_ack = 1; cpu_ack_vec = 5'(v);
    @(negedge clk); cpu_ack = 0;
    @(negedge clk);
  endtask

  task automatic expect_out(input string r, input int rq, input int v, input int l);
    chk({r, " req"}, cpu_req, rq);
    if (rq) begin
      chk({r, " vec"}, cpu_vec, v);
      chk({r, " lvl"}, cpu_lvl, l);
    end
  endtask

  function automatic int vmap(input int i);
    return i < 5 ? 4 + i : 6 + i;
  endfunction

  task automatic t_reset;
    int d;
    chk("R1 req", cpu_req, 0);
    rd(0, d); chk("R1 enable", d, 0);
    rd(1, d); chk("R1 pending", d, 0);
    for (int a = 2; a <= 8; a++) begin rd(a, d); chk("R1 level", d, 0); end
  endtask

  task automatic t_regs;
    int d;
    wr(2, 16'hFFFF); rd(2, d); chk("R2 packing", d, 16'h0707);
    wr(8, 16'h0536); rd(8, d); chk("R2 high pair", d, 16'h0506);
    wr(15, 16'hFFFF); rd(15, d); chk("R2 invalid addr", d, 0);
    for (int a = 0; a <= 8; a++) begin rd(a, d); if (a != 2 && a != 8) chk("R2 invalid write ignored", d, 0); end
    wr(2, 0); wr(8, 0);
  endtask

  task automatic t_level0;
    int d;
    wr(0, 16'h0001);
    pulse(1);
    expect_out("R4 level0 masked", 0, 0, 0);
    rd(1, d); chk("R3 sticky pending", d, 1);
    wr(2, 16'h0003);
    @(negedge clk);
    expect_out("R4 level set", 1, 4, 3);
    wr(0, 0); @(negedge clk);
    expect_out("R4 disabled", 0, 0, 0);
    wr(0, 1); @(negedge clk);
    expect_out("R4 re-enabled", 1, 4, 3);
    wr(1, 16'h0000); rd(1, d); chk("R3 write zero keeps", d, 1);
    wr(1, 16'h0001); rd(1, d); chk("R3 w1c", d, 0);
    @(negedge clk);
    expect_out("R4 drop", 0, 0, 0);
    wr(2, 0); wr(0, 0);
  endtask

  task automatic t_prio;
    int d;
    wr(0, 16'h3FFF);
    wr(3, 16'h0005);
    wr(5, 16'h0500);
    wr(6, 16'h0600);
    pulse((1 << 2) | (1 << 7) | (1 << 9));
    expect_out("R5 highest level", 1, 15, 6);
    ack(15);
    expect_out("R6 tie lowest vector", 1, 6, 5);
    rd(1, d); chk("R7 only acked cleared", d, (1 << 2) | (1 << 7));
    ack(6);
    expect_out("R7 next in order", 1, 13, 5);
    ack(13);
    expect_out("R7 drained", 0, 0, 0);
    wr(3, 0); wr(5, 0); wr(6, 0);
  endtask

  task automatic t_retarget;
    int d;
    wr(3, 16'h0200);
    wr(8, 16'h0004);
    pulse(1 << 3);
    expect_out("R8 first", 1, 7, 2);
    ack(9);
    expect_out("R7 unowned ack", 1, 7, 2);
    pulse(1 << 12);
    expect_out("R8 retarget", 1, 18, 4);
    rd(1, d); chk("R8 displaced pending", d, (1 << 3) | (1 << 12));
    ack(18);
    expect_out("R8 displaced returns", 1, 7, 2);
    ack(7);
    expect_out("R8 empty", 0, 0, 0);
    wr(3, 0); wr(8, 0);
  endtask

  task automatic t_vecmap;
    for (int a = 2; a <= 8; a++) wr(a, 16'h0101);
    for (int i = 0; i < 14; i++) begin
      pulse(1 << i);
      expect_out("R9 mapping", 1, vmap(i), 1);
      ack(vmap(i));
      expect_out("R9 ack clears", 0, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level0();
    t_prio();
    t_retarget();
    t_vecmap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule